// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Unit

This block keeps one control/status word per channel of a multi-channel DMA controller and condenses the channels' events into a controller-wide interrupt. Each channel engine sends single-cycle pulses for four events: descriptor start, descriptor end, bus error, and chain finished. The block latches the first three as sticky flags. It folds chain-finished into a stopped indication. It drives a run enable and a no-descriptor-fetch enable back to each engine.

Software reaches the block over a simple register bus with separate read and write strobes. It finds pending channels in a summary word that has one bit per channel. It acknowledges a channel by reading that channel's status word and writing the same value back. That write clears exactly the flags that were set when the word was read and leaves the control bits unchanged. A single interrupt line is the OR of all summary bits.

Top module: `dma_csr_irq`

## Requirements
- R1: After reset all run, no-fetch and stop-interrupt-enable bits are 0, all flags are 0, the summary word and the interrupt line are 0, and every channel status word reads 0x00000008 (stopped only).
- R2: Channel i's status word sits at byte address 4*i and the summary word at 0xF0, zero-extended. Read data appears on the cycle after the read strobe. Any other address reads 0, and writes to it change nothing.
- R3: In the status word, bit 31 is run, bit 30 is no-descriptor-fetch and bit 29 is stop-interrupt enable, all read/write. The run and no-fetch outputs follow a write from the next cycle and change only on a write.
- R4: Bit 8 reads the channel's request-pending input. Bit 3 reads 1 while run is 0, or after a chain-finished pulse, until run is written from 0 to 1. Writes to bits 8 and 3 have no effect.
- R5: A pulse on end, start or bus error sets sticky flag bit 2, 1 or 0 respectively. Writing a 1 to a flag bit clears it, and writing a 0 leaves it set.
- R6: An event pulse in the same cycle as a write-one-to-clear of its flag leaves the flag set.
- R7: Summary bit i is 1 when channel i has any flag set, or when its stop-interrupt enable is 1 and it is stopped. The summary bit is registered one cycle behind the flags. The interrupt output is the OR of all summary bits.
- R8: Writing back a status word just read clears all flags that were set and leaves run, no-fetch and stop-interrupt enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ev_end | input | NCH | Descriptor-end pulse per channel |
| ev_start | input | NCH | Descriptor-start pulse per channel |
| ev_berr | input | NCH | Bus-error pulse per channel |
| ev_chain_done | input | NCH | Chain-finished pulse per channel |
| req_pend | input | NCH | Request-pending level per channel |
| run_en | output | NCH | Run enable per channel |
| nodesc_en | output | NCH | No-descriptor-fetch enable per channel |
| irq_summary | output | NCH | Pending-interrupt bit per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the event inputs are single-cycle pulses, that bus reads and writes are never issued in the same cycle, and that the address only matters while a strobe is high.

The stimulus drives each pulse for exactly one cycle, on the falling edge. It runs bus accesses one at a time, with an idle cycle between them. The one case where an event and a clearing write share a cycle is set up deliberately, to check that the event wins.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int RUN_B     = 31;
  localparam int NODESC_B  = 30;
  localparam int STOPIE_B  = 29;
  localparam int REQ_B     = 8;
  localparam int STOPPED_B = 3;
  localparam int NFLAG     = 3;

  typedef struct packed {
    logic run;
    logic nodesc;
    logic stop_ie;
  } chan_ctrl_t;
endpackage

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  chan_ctrl_t       wr_ctrl,
  input  logic [NFLAG-1:0] wr_clr,
  input  logic [NFLAG-1:0] ev,
  input  logic             ev_done,
  input  logic             req_pend,
  output chan_ctrl_t       ctrl,
  output logic             pend,
  output logic [NFLAG-1:0] flags,
  output logic [31:0]      word
);
  logic done;
  logic stopped;
  logic [NFLAG-1:0] clr;

  assign clr = wr_hit ? wr_clr : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      flags <= '0;
      done  <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | ev;
      if (wr_hit) ctrl <= wr_ctrl;
      if (ev_done) done <= 1'b1;
      else if (wr_hit && wr_ctrl.run && !ctrl.run) done <= 1'b0;
    end
  end

  assign stopped = !ctrl.run || done;
  assign pend    = (|flags) || (ctrl.stop_ie && stopped);

  always_comb begin
    word              = '0;
    word[RUN_B]       = ctrl.run;
    word[NODESC_B]    = ctrl.nodesc;
    word[STOPIE_B]    = ctrl.stop_ie;
    word[REQ_B]       = req_pend;
    word[STOPPED_B]   = stopped;
    word[NFLAG-1:0]   = flags;
  end
endmodule

// File: rtl/dma_csr_sum.sv
module dma_csr_sum #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pend,
  output logic [NCH-1:0] summary,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      summary <= '0;
      irq     <= 1'b0;
    end else begin
      summary <= pend;
      irq     <= |pend;
    end
  end
endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux #(
  parameter int NCH      = 8,
  parameter int AW       = 8,
  parameter int SUM_ADDR = 'hF0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd,
  input  logic [AW-1:0]        addr,
  input  logic [NCH-1:0][31:0] words,
  input  logic [NCH-1:0]       summary,
  output logic [31:0]          rdata
);
  localparam int IW = AW - 2;
  logic [IW-1:0] widx;
  logic [31:0]   sel;

  assign widx = addr[AW-1:2];

  always_comb begin
    sel = '0;
    if (addr == AW'(SUM_ADDR)) begin
      sel[NCH-1:0] = summary;
    end else if (addr[1:0] == 2'b00) begin
      for (int i = 0; i < NCH; i++)
        if (widx == IW'(i)) sel = words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq
  import dma_csr_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int AW       = 8,
  parameter int SUM_ADDR = 'hF0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] ev_end,
  input  logic [NCH-1:0] ev_start,
  input  logic [NCH-1:0] ev_berr,
  input  logic [NCH-1:0] ev_chain_done,
  input  logic [NCH-1:0] req_pend,
  output logic [NCH-1:0] run_en,
  output logic [NCH-1:0] nodesc_en,
  output logic [NCH-1:0] irq_summary,
  output logic           irq
);
  logic [NCH-1:0][31:0]      words;
  logic [NCH-1:0][NFLAG-1:0] flg;
  logic [NCH-1:0]            pend;
  logic [NCH-1:0]            wr_hit;
  chan_ctrl_t                wr_ctrl;
  logic                      unused_wbits;

  assign wr_ctrl      = '{run: bus_wdata[RUN_B], nodesc: bus_wdata[NODESC_B],
                          stop_ie: bus_wdata[STOPIE_B]};
  assign unused_wbits = ^bus_wdata[28:NFLAG];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_ctrl_t ctrl;
    assign wr_hit[i]    = bus_wr && (bus_addr == AW'(4 * i));
    assign run_en[i]    = ctrl.run;
    assign nodesc_en[i] = ctrl.nodesc;
    dma_csr_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (wr_hit[i]),
      .wr_ctrl  (wr_ctrl),
      .wr_clr   (bus_wdata[NFLAG-1:0]),
      .ev       ({ev_end[i], ev_start[i], ev_berr[i]}),
      .ev_done  (ev_chain_done[i]),
      .req_pend (req_pend[i]),
      .ctrl     (ctrl),
      .pend     (pend[i]),
      .flags    (flg[i]),
      .word     (words[i])
    );
  end

  dma_csr_sum #(.NCH(NCH)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend),
    .summary (irq_summary),
    .irq     (irq)
  );

  dma_csr_rdmux #(.NCH(NCH), .AW(AW), .SUM_ADDR(SUM_ADDR)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .words   (words),
    .summary (irq_summary),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/dma_csr_irq_chk.sv
module dma_csr_irq_chk #(
  parameter int NCH      = 8,
  parameter int AW       = 8,
  parameter int SUM_ADDR = 'hF0
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [AW-1:0]       bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NCH-1:0]      ev_end,
  input logic [NCH-1:0]      ev_start,
  input logic [NCH-1:0]      ev_berr,
  input logic [NCH-1:0]      run_en,
  input logic [NCH-1:0]      nodesc_en,
  input logic [NCH-1:0]      irq_summary,
  input logic                irq,
  input logic [NCH-1:0][2:0] flg
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_end_sets_R5: assert property (@(posedge clk) disable iff (rst)
      ev_end[i] |=> flg[i][2]);
    assert_start_sets_R5: assert property (@(posedge clk) disable iff (rst)
      ev_start[i] |=> flg[i][1]);
    assert_berr_sets_R5: assert property (@(posedge clk) disable iff (rst)
      ev_berr[i] |=> flg[i][0]);
    assert_flag_held_R5: assert property (@(posedge clk) disable iff (rst)
      (flg[i][2] && !bus_wr) |=> flg[i][2]);
    assert_summary_follows_R7: assert property (@(posedge clk) disable iff (rst)
      (|flg[i]) |=> irq_summary[i]);
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !bus_wr |=> ($stable(run_en[i]) && $stable(nodesc_en[i])));
  end

  assert_irq_or_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (|irq_summary));
  assert_read_summary_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(SUM_ADDR)) |=> (bus_rdata[NCH-1:0] == $past(irq_summary)));
endmodule

bind dma_csr_irq dma_csr_irq_chk #(.NCH(NCH), .AW(AW), .SUM_ADDR(SUM_ADDR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .ev_end      (ev_end),
  .ev_start    (ev_start),
  .ev_berr     (ev_berr),
  .run_en      (run_en),
  .nodesc_en   (nodesc_en),
  .irq_summary (irq_summary),
  .irq         (irq),
  .flg         (flg)
);

// File: tb/dma_csr_irq_bench.sv
module dma_csr_irq_bench;
  localparam int NCH = 4;
  localparam int AW  = 8;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] ev_end = '0, ev_start = '0, ev_berr = '0, ev_chain_done = '0, req_pend = '0;
  logic [NCH-1:0] run_en, nodesc_en, irq_summary;
  logic irq;

  int total = 0, fails = 0;
  bit finished = 0;

  logic m_run[NCH], m_nod[NCH], m_sie[NCH], m_done[NCH];
  logic [2:0] m_flags[NCH];

  always #10 clk = ~clk;

  dma_csr_irq #(.NCH(NCH), .AW(AW)) u_dma_csr_irq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_end(ev_end), .ev_start(ev_start),
    .ev_berr(ev_berr), .ev_chain_done(ev_chain_done), .req_pend(req_pend),
    .run_en(run_en), .nodesc_en(nodesc_en), .irq_summary(irq_summary), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int ch);
    logic stp = !m_run[ch] || m_done[ch];
    return {m_run[ch], m_nod[ch], m_sie[ch], 20'b0, req_pend[ch], 4'b0, stp, m_flags[ch]};
  endfunction

  function automatic logic [NCH-1:0] exp_sum();
    logic [NCH-1:0] s;
    for (int c = 0; c < NCH; c++)
      s[c] = (|m_flags[c]) || (m_sie[c] && (!m_run[c] || m_done[c]));
    return s;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic mwr(input int ch, input logic [31:0] d);
    wr(AW'(ch * 4), d);
    m_flags[ch] &= ~d[2:0];
    if (d[31] && !m_run[ch]) m_done[ch] = 0;
    m_run[ch] = d[31]; m_nod[ch] = d[30]; m_sie[ch] = d[29];
  endtask

  task automatic pulse(input int ch, input logic [2:0] s, input logic dn);
    @(negedge clk);
    ev_end[ch] = s[2]; ev_start[ch] = s[1]; ev_berr[ch] = s[0]; ev_chain_done[ch] = dn;
    @(negedge clk);
    ev_end = '0; ev_start = '0; ev_berr = '0; ev_chain_done = '0;
    @(negedge clk);
    m_flags[ch] |= s;
    if (dn) m_done[ch] = 1;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      rd(AW'(c * 4), d);
      chk(tag, d, exp_word(c));
    end
    rd(8'hF0, d);
    chk({tag, " summary"}, d, {28'b0, exp_sum()});
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, |exp_sum()});
    chk({tag, " port summary"}, {28'b0, irq_summary}, {28'b0, exp_sum()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w;
    for (int c = 0; c < NCH; c++) begin
      m_run[c] = 0; m_nod[c] = 0; m_sie[c] = 0; m_done[c] = 0; m_flags[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 run_en", {28'b0, run_en}, 32'h0);
    chk("R1 nodesc_en", {28'b0, nodesc_en}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    check_all("R1 reset");

    // R3 control bit sweep, R7 stop-interrupt contribution
    for (int c = 0; c < NCH; c++)
      for (int p = 0; p < 8; p++) begin
        mwr(c, {p[2:0], 29'b0});
        chk("R3 run_en", {31'b0, run_en[c]}, {31'b0, p[2]});
        chk("R3 nodesc_en", {31'b0, nodesc_en[c]}, {31'b0, p[1]});
        check_all("R3 R7 ctrl");
      end
    for (int c = 0; c < NCH; c++) mwr(c, 32'h0);

    // R5 flag set / write-one-to-clear sweep
    for (int c = 0; c < NCH; c++)
      for (int s = 1; s < 8; s++)
        for (int m = 0; m < 8; m++) begin
          pulse(c, s[2:0], 1'b0);
          rd(AW'(c * 4), d);
          chk("R5 set", d, exp_word(c));
          chk("R7 irq", {31'b0, irq}, 32'h1);
          mwr(c, {29'b0, m[2:0]});
          rd(AW'(c * 4), d);
          chk("R5 clear", d, exp_word(c));
          mwr(c, 32'h7);
        end
    check_all("R5 after sweep");

    // R6 event during clear
    pulse(2, 3'b111, 1'b0);
    @(negedge clk); bus_wr = 1; bus_addr = 8'h08; bus_wdata = 32'h7; ev_end[2] = 1;
    @(negedge clk); bus_wr = 0; ev_end = '0;
    m_flags[2] = 3'b100;
    rd(8'h08, d);
    chk("R6 event wins", d, exp_word(2));
    mwr(2, 32'h7);

    // R8 read back, write back
    mwr(1, 32'hE000_0000);
    pulse(1, 3'b101, 1'b0);
    rd(8'h04, w);
    chk("R8 word before", w, exp_word(1));
    mwr(1, w);
    rd(8'h04, d);
    chk("R8 cleared", d, 32'hE000_0000);
    chk("R8 run kept", {31'b0, run_en[1]}, 32'h1);
    check_all("R8 all");

    // R4 request pending, stopped, read-only bits
    req_pend[3] = 1;
    mwr(3, 32'h8000_0108);
    rd(8'h0C, d);
    chk("R4 reqpend running", d, 32'h8000_0100);
    pulse(3, 3'b000, 1'b1);
    rd(8'h0C, d);
    chk("R4 stopped after chain", d, 32'h8000_0108);
    mwr(3, 32'hA000_0000);
    check_all("R4 R7 stop irq while running");
    mwr(3, 32'h2000_0000);
    mwr(3, 32'hA000_0000);
    rd(8'h0C, d);
    chk("R4 restart clears stopped", d, 32'hA000_0100);
    req_pend[3] = 0;
    mwr(3, 32'h0);

    // R2 decode: stray writes ignored, stray reads return zero
    pulse(0, 3'b011, 1'b0);
    wr(8'h10, 32'hE000_0007);
    wr(8'h01, 32'hE000_0007);
    wr(8'h02, 32'hE000_0007);
    wr(8'hF0, 32'hFFFF_FFFF);
    check_all("R2 stray writes");
    rd(8'h10, d); chk("R2 unmapped", d, 32'h0);
    rd(8'h03, d); chk("R2 misaligned", d, 32'h0);
    rd(8'hEC, d); chk("R2 gap", d, 32'h0);

    // R7 multiple channels pending
    pulse(3, 3'b100, 1'b0);
    check_all("R7 two channels");
    mwr(0, 32'h7);
    mwr(3, 32'h7);
    check_all("R7 cleared");

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule